// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream on three wires (a bit clock, a frame clock that tells left from right, and a serial data line) and turns it into one parallel left sample and one parallel right sample per frame. A 3-bit framing code chooses between I2S-compatible framing, MSB-justified framing and LSB-justified framing, each at a fixed word length. Every sample is presented as a 24-bit two's-complement word, and a single-cycle strobe marks each new stereo pair.

The whole block runs on the serial bit clock. The power-down input acts as a synchronous reset. The framing code is loaded only while power-down is held. For LSB-justified framing the receiver keeps shifting for the whole half frame and keeps the last N bits, so the word ends on the bit just before the frame-clock transition. For the other framings it stores the first N bits. A half frame that carries fewer bits than the word length flags an error for that frame and no samples are delivered for it.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` is loaded into the block at every rising bit-clock edge where `pwr_dn` is high. Changes to `fmt_sel` while `pwr_dn` is low have no effect on decoding. Codes: 0 = LSB-justified 16-bit, 1 = LSB-justified 20-bit, 2 = LSB-justified 24-bit, 3 = MSB-justified 20-bit, 4 = MSB-justified 24-bit, 5 = I2S 16-bit, 6 = I2S 24-bit.
- R2: While `pwr_dn` is high, at the next rising edge `left_smp` and `right_smp` go to zero and `smp_valid` and `frame_err` go low.
- R3: Serial data is sampled on the rising bit-clock edge and arrives MSB first. In MSB-justified framing, `frame_clk` high marks the left half, and the MSB is the first bit sampled after the frame clock changes.
- R4: In I2S framing (codes 5, 6 and 7), `frame_clk` low marks the left half, and the MSB is sampled one bit clock after the frame-clock transition.
- R5: In LSB-justified framing the sample is made up of the last N bits of the half frame, where N is the word length. Bits earlier in the half are ignored.
- R6: Words shorter than 24 bits appear in the upper bits of the output, with the low bits zero. In MSB-justified and I2S framing, bits after the first N bits of a half are ignored.
- R7: `smp_valid` is high for exactly one cycle. It starts at the rising edge that samples the first bit of the next left half. That edge is one clock after the frame clock changes in I2S framing. `left_smp` and `right_smp` take their new values at that same edge.
- R8: If the left or right half of a frame carries fewer than N bits, `frame_err` pulses for one cycle instead of `smp_valid`, and `left_smp` and `right_smp` keep their previous values.
- R9: A frame of 32 bit clocks (16 per half) decodes correctly for the 16-bit LSB-justified and 16-bit I2S framings.
- R10: The half frame in progress when power-down is released is discarded. The first strobe follows the first complete left half and the complete right half after it.
- R11: Code 7 decodes exactly like code 6 (I2S 24-bit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| pwr_dn | input | 1 | Power-down; synchronous active-high reset that also loads the framing code |
| fmt_sel | input | 3 | Framing code, loaded only while power-down is high |
| frame_clk | input | 1 | Left/right frame clock |
| ser_din | input | 1 | Serial audio data, MSB first |
| left_smp | output | 24 | Left sample, two's complement, left-aligned |
| right_smp | output | 24 | Right sample, two's complement, left-aligned |
| smp_valid | output | 1 | One-cycle strobe when a new stereo pair is presented |
| frame_err | output | 1 | One-cycle strobe when a frame had a short half |

## Verification
A bit counter that drifts, or a frame phase held in the wrong state, shows at the ports within one frame. The sample values shift by whole bit positions, the strobe moves by a cycle or lands on the wrong half, or a spurious error pulse appears. A shifter that keeps shifting too long in MSB-justified or I2S framing, or stops too early in LSB-justified framing, shows on the first strobe as the wrong word or as non-zero low bits. A framing code that leaks in while running shows on the next frame as a changed word width or channel order.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int WL_W     = 5;

    typedef enum logic [2:0] {
        FMT_LSB16  = 3'd0,
        FMT_LSB20  = 3'd1,
        FMT_LSB24  = 3'd2,
        FMT_MSB20  = 3'd3,
        FMT_MSB24  = 3'd4,
        FMT_I2S16  = 3'd5,
        FMT_I2S24  = 3'd6,
        FMT_I2S24B = 3'd7
    } fmt_e;

    // Decoded framing: keep-last-N shifting, one-bit frame delay, word length
    typedef struct packed {
        logic            tail_keep;
        logic            lag_one;
        logic [WL_W-1:0] wlen;
    } rx_cfg_t;

    typedef enum logic [1:0] {
        LH_NONE  = 2'd0,
        LH_GOOD  = 2'd1,
        LH_SHORT = 2'd2
    } lhalf_e;

    function automatic rx_cfg_t decode_fmt(input logic [2:0] code);
        rx_cfg_t c;
        unique case (fmt_e'(code))
            FMT_LSB16: c = '{tail_keep: 1'b1, lag_one: 1'b0, wlen: 5'd16};
            FMT_LSB20: c = '{tail_keep: 1'b1, lag_one: 1'b0, wlen: 5'd20};
            FMT_LSB24: c = '{tail_keep: 1'b1, lag_one: 1'b0, wlen: 5'd24};
            FMT_MSB20: c = '{tail_keep: 1'b0, lag_one: 1'b0, wlen: 5'd20};
            FMT_MSB24: c = '{tail_keep: 1'b0, lag_one: 1'b0, wlen: 5'd24};
            FMT_I2S16: c = '{tail_keep: 1'b0, lag_one: 1'b1, wlen: 5'd16};
            default:   c = '{tail_keep: 1'b0, lag_one: 1'b1, wlen: 5'd24};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sarx_cfg.sv
module sarx_cfg
    import sarx_pkg::*;
(
    input  logic       clk,
    input  logic       pwr_dn,
    input  logic [2:0] fmt_code,
    output rx_cfg_t    cfg
);

    always_ff @(posedge clk) begin
        if (pwr_dn) begin
            cfg <= decode_fmt(fmt_code);
        end
    end

    // R1: configuration frozen while running
    assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (pwr_dn)
        !$past(pwr_dn) |-> $stable(cfg));

endmodule

// File: rtl/sarx_phase.sv
module sarx_phase
    import sarx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             pwr_dn,
    input  rx_cfg_t          cfg,
    input  logic             frame_clk,
    output logic             bnd,
    output logic             done_left,
    output logic             primed,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic fc_q;
    logic started;
    logic prev_left;
    logic is_left;

    // In I2S framing the half boundary trails the frame clock by one bit
    assign is_left   = cfg.lag_one ? ~fc_q : frame_clk;
    assign bnd       = started && (is_left != prev_left);
    assign done_left = prev_left;

    always_ff @(posedge clk) begin
        if (pwr_dn) begin
            fc_q      <= 1'b0;
            started   <= 1'b0;
            prev_left <= 1'b0;
            primed    <= 1'b0;
            bit_cnt   <= '0;
        end else begin
            fc_q      <= frame_clk;
            started   <= 1'b1;
            prev_left <= is_left;
            if (bnd) begin
                primed  <= 1'b1;
                bit_cnt <= CNT_W'(1);
            end else if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R5: each half restarts its bit count from the first bit
    assert_half_restart_R5: assert property (@(posedge clk) disable iff (pwr_dn)
        bnd |=> (bit_cnt == CNT_W'(1)));

endmodule

// File: rtl/sarx_shift.sv
module sarx_shift
    import sarx_pkg::*;
#(
    parameter int SMP_W = SAMPLE_W,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             pwr_dn,
    input  rx_cfg_t          cfg,
    input  logic             ser_din,
    input  logic             bnd,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic [SMP_W-1:0] word
);

    logic [SMP_W-1:0] sh;
    logic [SMP_W-1:0] keep_mask;
    logic             shift_en;
    int               wl_i;

    assign wl_i     = int'(cfg.wlen);
    assign shift_en = cfg.tail_keep || (bit_cnt < CNT_W'(cfg.wlen));

    always_ff @(posedge clk) begin
        if (pwr_dn) begin
            sh <= '0;
        end else if (bnd) begin
            sh <= {{(SMP_W-1){1'b0}}, ser_din};
        end else if (shift_en) begin
            sh <= {sh[SMP_W-2:0], ser_din};
        end
    end

    always_comb begin
        for (int i = 0; i < SMP_W; i++) begin
            keep_mask[i] = (i < wl_i);
        end
        word = (sh & keep_mask) << (SMP_W - wl_i);
    end

    // R6: once N bits are held in a head-keeping framing, the shifter freezes
    assert_head_frozen_R6: assert property (@(posedge clk) disable iff (pwr_dn)
        (!cfg.tail_keep && !bnd && (bit_cnt >= CNT_W'(cfg.wlen))) |=> $stable(sh));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int SMP_W = SAMPLE_W,
    parameter int CNT_W = 7
) (
    input  logic             bclk,
    input  logic             pwr_dn,
    input  logic [2:0]       fmt_sel,
    input  logic             frame_clk,
    input  logic             ser_din,
    output logic [SMP_W-1:0] left_smp,
    output logic [SMP_W-1:0] right_smp,
    output logic             smp_valid,
    output logic             frame_err
);

    rx_cfg_t          cfg;
    logic             bnd;
    logic             done_left;
    logic             primed;
    logic [CNT_W-1:0] bit_cnt;
    logic [SMP_W-1:0] word;
    logic [SMP_W-1:0] left_hold;
    lhalf_e           lstate;
    logic             half_ok;

    sarx_cfg u_cfg (
        .clk      (bclk),
        .pwr_dn   (pwr_dn),
        .fmt_code (fmt_sel),
        .cfg      (cfg)
    );

    sarx_phase #(.CNT_W(CNT_W)) u_phase (
        .clk       (bclk),
        .pwr_dn    (pwr_dn),
        .cfg       (cfg),
        .frame_clk (frame_clk),
        .bnd       (bnd),
        .done_left (done_left),
        .primed    (primed),
        .bit_cnt   (bit_cnt)
    );

    sarx_shift #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_shift (
        .clk     (bclk),
        .pwr_dn  (pwr_dn),
        .cfg     (cfg),
        .ser_din (ser_din),
        .bnd     (bnd),
        .bit_cnt (bit_cnt),
        .word    (word)
    );

    assign half_ok = (bit_cnt >= CNT_W'(cfg.wlen));

    always_ff @(posedge bclk) begin
        if (pwr_dn) begin
            left_smp  <= '0;
            right_smp <= '0;
            left_hold <= '0;
            lstate    <= LH_NONE;
            smp_valid <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            frame_err <= 1'b0;
            if (bnd && primed) begin
                if (done_left) begin
                    left_hold <= word;
                    lstate    <= half_ok ? LH_GOOD : LH_SHORT;
                end else begin
                    if (lstate == LH_GOOD && half_ok) begin
                        left_smp  <= left_hold;
                        right_smp <= word;
                        smp_valid <= 1'b1;
                    end else if (lstate != LH_NONE) begin
                        frame_err <= 1'b1;
                    end
                    lstate <= LH_NONE;
                end
            end
        end
    end

    // Low-bit mask for the alignment check
    logic [SMP_W-1:0] low_bits;
    always_comb begin
        for (int i = 0; i < SMP_W; i++) begin
            low_bits[i] = (i < (SMP_W - int'(cfg.wlen)));
        end
    end

    // R2: power-down clears the outputs
    assert_pd_clears_R2: assert property (@(posedge bclk)
        pwr_dn |=> (left_smp == '0 && right_smp == '0 && !smp_valid && !frame_err));

    // R7: strobe lasts one cycle
    assert_strobe_single_R7: assert property (@(posedge bclk) disable iff (pwr_dn)
        smp_valid |=> !smp_valid);

    // R8: error and strobe never together
    assert_err_excl_R8: assert property (@(posedge bclk) disable iff (pwr_dn)
        !(smp_valid && frame_err));

    // R8: samples hold between strobes
    assert_hold_between_R8: assert property (@(posedge bclk) disable iff (pwr_dn)
        !smp_valid |-> ($stable(left_smp) && $stable(right_smp)));

    // R6: short words arrive with zero low bits
    assert_aligned_R6: assert property (@(posedge bclk) disable iff (pwr_dn)
        smp_valid |-> (((left_smp | right_smp) & low_bits) == '0));

endmodule

// File: tb/serial_audio_rx_test.sv
module serial_audio_rx_test;

    localparam int PERIOD = 10;
    localparam int W      = 24;

    logic         bclk      = 1'b0;
    logic         pwr_dn    = 1'b1;
    logic [2:0]   fmt_sel   = 3'd4;
    logic         frame_clk = 1'b0;
    logic         ser_din   = 1'b0;
    logic [W-1:0] left_smp;
    logic [W-1:0] right_smp;
    logic         smp_valid;
    logic         frame_err;

    always #(PERIOD/2) bclk = ~bclk;

    serial_audio_rx uut (
        .bclk      (bclk),
        .pwr_dn    (pwr_dn),
        .fmt_sel   (fmt_sel),
        .frame_clk (frame_clk),
        .ser_din   (ser_din),
        .left_smp  (left_smp),
        .right_smp (right_smp),
        .smp_valid (smp_valid),
        .frame_err (frame_err)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R2";

    bit lr_stream[$];
    bit sd_stream[$];

    // behavioural reference state
    logic [2:0]   m_fmt = 3'd0;
    bit           m_started, m_prev_lr, m_prev_left, m_primed;
    bit           half_q[$];
    int           lstate;
    logic [W-1:0] lhold, exp_l, exp_r;
    bit           exp_v, exp_e;

    int           nvalid, nerr;
    logic [W-1:0] got_l, got_r;
    logic [2:0]   cur_code;

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int wl_of(input logic [2:0] c);
        case (c)
            3'd0: return 16;
            3'd1: return 20;
            3'd3: return 20;
            3'd5: return 16;
            default: return 24;
        endcase
    endfunction

    task automatic eval_half(input bit was_left);
        int           n, nw;
        bit           ok;
        logic [W-1:0] w;
        n  = half_q.size();
        nw = wl_of(m_fmt);
        ok = (n >= nw);
        w  = '0;
        if (ok) begin
            for (int i = 0; i < nw; i++) begin
                w = {w[W-2:0], (m_fmt < 3'd3) ? half_q[n - nw + i] : half_q[i]};
            end
            w = w << (W - nw);
        end
        if (was_left) begin
            lstate = ok ? 1 : 2;
            lhold  = w;
        end else begin
            if (lstate == 1 && ok) begin
                exp_l = lhold;
                exp_r = w;
                exp_v = 1'b1;
            end else if (lstate != 0) begin
                exp_e = 1'b1;
            end
            lstate = 0;
        end
    endtask

    task automatic model_step(input bit pd, input bit lr, input bit sd);
        bit isl;
        exp_v = 1'b0;
        exp_e = 1'b0;
        if (pd) begin
            m_fmt = fmt_sel;
            m_started = 0; m_prev_lr = 0; m_prev_left = 0; m_primed = 0;
            half_q.delete();
            lstate = 0; lhold = '0; exp_l = '0; exp_r = '0;
            return;
        end
        isl = (m_fmt >= 3'd5) ? !m_prev_lr : lr;
        if (m_started && (isl != m_prev_left)) begin
            if (m_primed) eval_half(m_prev_left);
            m_primed = 1;
            half_q.delete();
        end
        half_q.push_back(sd);
        m_prev_lr   = lr;
        m_prev_left = isl;
        m_started   = 1;
    endtask

    // model, per-cycle compare, then drive the next bit
    always @(negedge bclk) begin
        model_step(pwr_dn, frame_clk, ser_din);
        chk("R7", "valid", {23'd0, smp_valid}, {23'd0, exp_v});
        chk("R8", "error", {23'd0, frame_err}, {23'd0, exp_e});
        chk(cur_req, "left",  left_smp,  exp_l);
        chk(cur_req, "right", right_smp, exp_r);
        if (smp_valid) begin
            nvalid++;
            got_l = left_smp;
            got_r = right_smp;
        end
        if (frame_err) nerr++;
        if (lr_stream.size() > 0) frame_clk <= lr_stream.pop_front();
        if (sd_stream.size() > 0) ser_din <= sd_stream.pop_front();
        else ser_din <= 1'b0;
    end

    task automatic push_half(input bit lrv, input int nbits, input logic [W-1:0] val);
        int wl;
        bit tail;
        wl   = wl_of(cur_code);
        tail = (cur_code < 3'd3);
        for (int i = 0; i < nbits; i++) begin
            int j;
            lr_stream.push_back(lrv);
            if (tail) begin
                j = nbits - 1 - i;
                sd_stream.push_back(j < wl ? val[j] : 1'b1);
            end else begin
                sd_stream.push_back(i < wl ? val[wl - 1 - i] : 1'b1);
            end
        end
    endtask

    function automatic bit left_lvl();
        return (cur_code >= 3'd5) ? 1'b0 : 1'b1;
    endfunction

    task automatic frame(input int bl, input int br, input logic [W-1:0] lv, input logic [W-1:0] rv);
        push_half(left_lvl(), bl, lv);
        push_half(~left_lvl(), br, rv);
    endtask

    task automatic begin_case(input logic [2:0] code, input string tag, input bit chk_pd);
        @(negedge bclk); #1;
        pwr_dn  = 1'b1;
        fmt_sel = code;
        cur_req = "R2";
        repeat (3) @(negedge bclk);
        #1;
        if (chk_pd) begin
            chk("R2", "left held at zero in power-down",  left_smp,  '0);
            chk("R2", "right held at zero in power-down", right_smp, '0);
        end
        cur_req  = tag;
        cur_code = code;
        nvalid   = 0;
        nerr     = 0;
        if (code >= 3'd5) sd_stream.push_back(1'b0);
        push_half(~left_lvl(), 6, '0);
    endtask

    task automatic release_pd();
        pwr_dn = 1'b0;
    endtask

    task automatic end_case();
        push_half(left_lvl(), 8, '0);
        while (lr_stream.size() > 0 || sd_stream.size() > 0) @(negedge bclk);
        repeat (3) @(negedge bclk);
        #1;
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge bclk);
        #1;
        // R2 reset state
        chk("R2", "reset valid", {23'd0, smp_valid}, 24'd0);
        chk("R2", "reset left", left_smp, '0);

        // R3 MSB-justified 24-bit, two frames, filler ones after word
        begin_case(3'd4, "R3", 1'b0); release_pd();
        frame(32, 32, 24'hA5C3E1, 24'h123456);
        frame(32, 32, 24'h5A3C1E, 24'hFEDCBA);
        end_case();
        chk("R3", "msb24 left", got_l, 24'h5A3C1E);
        chk("R3", "msb24 right", got_r, 24'hFEDCBA);
        chk("R10", "strobe count", W'(nvalid), 24'd2);

        // R4 I2S 24-bit
        begin_case(3'd6, "R4", 1'b1); release_pd();
        frame(32, 32, 24'h800001, 24'h7FFFFE);
        end_case();
        chk("R4", "i2s24 left", got_l, 24'h800001);
        chk("R4", "i2s24 right", got_r, 24'h7FFFFE);
        chk("R10", "strobe count", W'(nvalid), 24'd1);

        // R9 / R5 LSB-justified 16-bit at 32 clocks per frame
        begin_case(3'd0, "R9", 1'b0); release_pd();
        frame(16, 16, 24'h00BEEF, 24'h000123);
        end_case();
        chk("R9", "lsb16 left", got_l, 24'hBEEF00);
        chk("R9", "lsb16 right", got_r, 24'h012300);

        // R5 LSB-justified 20-bit with leading filler
        begin_case(3'd1, "R5", 1'b0); release_pd();
        frame(24, 24, 24'h0ABCDE, 24'h013579);
        end_case();
        chk("R5", "lsb20 left", got_l, 24'hABCDE0);
        chk("R5", "lsb20 right", got_r, 24'h135790);

        // R5 LSB-justified 24-bit in 32-bit halves
        begin_case(3'd2, "R5", 1'b0); release_pd();
        frame(32, 32, 24'hC0FFEE, 24'h0BADF0);
        end_case();
        chk("R5", "lsb24 left", got_l, 24'hC0FFEE);
        chk("R5", "lsb24 right", got_r, 24'h0BADF0);

        // R9 I2S 16-bit at 32 clocks per frame
        begin_case(3'd5, "R9", 1'b0); release_pd();
        frame(16, 16, 24'h001234, 24'h00FEDC);
        end_case();
        chk("R9", "i2s16 left", got_l, 24'h123400);
        chk("R9", "i2s16 right", got_r, 24'hFEDC00);

        // R6 MSB-justified 20-bit, trailing ones ignored
        begin_case(3'd3, "R6", 1'b0); release_pd();
        frame(32, 32, 24'h0FFFFF, 24'h000001);
        end_case();
        chk("R6", "msb20 left", got_l, 24'hFFFFF0);
        chk("R6", "msb20 right", got_r, 24'h000010);

        // R8 short left half
        begin_case(3'd4, "R8", 1'b0); release_pd();
        frame(20, 32, 24'h111111, 24'h222222);
        frame(32, 32, 24'h333333, 24'h444444);
        end_case();
        chk("R8", "error count", W'(nerr), 24'd1);
        chk("R8", "strobe count", W'(nvalid), 24'd1);
        chk("R8", "left after recovery", got_l, 24'h333333);

        // R1 code change while running is ignored
        begin_case(3'd4, "R1", 1'b0); release_pd();
        @(negedge bclk); #1;
        fmt_sel = 3'd0;
        frame(32, 32, 24'h654321, 24'h0FEDCB);
        end_case();
        chk("R1", "left kept msb24", got_l, 24'h654321);
        chk("R1", "right kept msb24", got_r, 24'h0FEDCB);

        // R11 code 7 acts as I2S 24-bit
        begin_case(3'd7, "R11", 1'b0); release_pd();
        frame(32, 32, 24'h13579B, 24'h2468AC);
        end_case();
        chk("R11", "code7 left", got_l, 24'h13579B);
        chk("R11", "code7 right", got_r, 24'h2468AC);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule